// File: doc/BRIEF.md
# Ring and Tone Generator

This block synthesizes ringing, call-progress and keypad tone pairs as a signed sample stream at the voice sample rate. On every sample strobe it reads its control inputs and emits one 16-bit sample two clock cycles later. The sample is one tone, or the sum of two tones. Each tone is either a sampled sine or a square wave, and the result is scaled by a stepped attenuator. A destination code travels with each sample and tells the downstream mixer which path takes it: earpiece, loudspeaker or transmit amplifier.

The block has two control modes. Under processor control, an enable bit and the programmed frequency words set the sound; sweeps and cadence come from the processor rewriting those inputs. Under external control, a three-level "alternate tone" pin, already resolved into a valid bit and a value bit, picks frequency 1, frequency 2 or a pause. No processor action is needed for this.

Each tone has a phase accumulator that advances by its frequency word once per strobe. A quarter-wave table of 64 points, indexed by the upper phase bits, produces the sine.

Top module: `tone_gen`

## Requirements
- R1: `out_valid` is high for exactly the cycle two clock edges after each `sample_en` edge, and one sample is produced per strobe.
- R2: Each accumulator is 16 bits wide and is zero when a tone starts. The sample for a strobe uses the phase before that strobe's advance. In square mode a single tone at code 0 gives +32767 when phase bit 15 is 0 and -32767 when it is 1.
- R3: In sine mode a single tone at code 0 gives 32767·sin(2π·(P+0.5)/256) to within 64 LSB, where P is phase bits 15:8.
- R4: When `dual` is set under processor control, each tone is arithmetically shifted right by one bit and the two are added; `freq1` drives tone A and `freq2` drives tone B.
- R5: Attenuation code k in 0..9 scales the sample by 10^(-3k/20), giving 0 to 27 dB in 3 dB steps, to within 2 LSB; code 0 is exact unity. Codes 10..15 output zero.
- R6: Under processor control with `tone_on` low, the sample is zero and both accumulators return to phase 0.
- R7: Under external control with `at_valid` high, the block plays one tone at `freq1` when `at_value` is 1 and at `freq2` when it is 0; `dual` and `tone_on` are ignored.
- R8: Under external control with `at_valid` low (pause), the sample is zero and the accumulator returns to phase 0.
- R9: Switching between `freq1` and `freq2` under external control keeps the phase continuous: the accumulator keeps its value and only its increment changes.
- R10: `dest` is one-hot, decoded from the `route` value sampled at the same strobe as the sample: 0 gives 001 (earpiece), 1 gives 010 (loudspeaker), 2 gives 100 (transmit), and 3 gives 000.
- R11: After reset, `out_valid`, `out_sample` and `dest` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle strobe per output sample |
| tone_on | input | 1 | Generator enable under processor control |
| ext_ctrl | input | 1 | 1 selects external alternate-tone control |
| at_valid | input | 1 | Alternate-tone pin driven (0 means pause) |
| at_value | input | 1 | Alternate-tone level: 1 selects freq1, 0 selects freq2 |
| dual | input | 1 | Sum of two tones under processor control |
| square | input | 1 | 1 square wave, 0 sine |
| freq1 | input | 16 | Phase increment of tone 1 |
| freq2 | input | 16 | Phase increment of tone 2 |
| atten | input | 4 | Attenuation code, 3 dB per step |
| route | input | 2 | Destination select |
| out_valid | output | 1 | Sample strobe |
| out_sample | output | 16 | Signed output sample |
| dest | output | 3 | One-hot destination |

## Verification
The bench builds the block with its default parameters: 16-bit phase and sample, a 64-point quarter table and a 4-bit attenuation code. The 4-bit code reaches the muted codes 10 to 15 as well as every step of the 27 dB range. With 16-bit frequency words the bench uses increments of a few thousand, so the phase crosses every quadrant within a handful of samples and both mirroring and sign inversion of the sine table are exercised. It also runs external frequency switching in the middle of a tone and pause recovery, checked against a phase model kept in the bench.

// File: rtl/tg_pkg.sv
package tg_pkg;

  typedef enum logic [1:0] {
    RT_EAR  = 2'd0,
    RT_SPK  = 2'd1,
    RT_TX   = 2'd2,
    RT_NONE = 2'd3
  } route_e;

  // One-hot destination decode of the route field.
  function automatic logic [2:0] route_onehot(input logic [1:0] r);
    case (route_e'(r))
      RT_EAR:  return 3'b001;
      RT_SPK:  return 3'b010;
      RT_TX:   return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  // Q15 gain per 3 dB step; code 0 is exact unity, codes past 9 mute.
  function automatic int gain_q15(input int code);
    case (code)
      0: return 32768;
      1: return 23198;
      2: return 16423;
      3: return 11627;
      4: return 8231;
      5: return 5827;
      6: return 4125;
      7: return 2920;
      8: return 2068;
      9: return 1464;
      default: return 0;
    endcase
  endfunction

  // Quarter-wave point i at angle (i+0.5) table steps, rational sine fit.
  function automatic int sine_pt(input int i, input int tbl_bits, input int amp);
    longint h, v, p;
    h = longint'(1) << (tbl_bits + 2);
    v = 2 * longint'(i) + 1;
    p = v * (h - v);
    return int'((longint'(amp) * 16 * p) / (5 * h * h - 4 * p));
  endfunction

endpackage

// File: rtl/tg_phase.sv
module tg_phase #(
  parameter int PW = 16,
  parameter int OB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          run,
  input  logic [PW-1:0] inc,
  output logic [OB-1:0] ph_top
);

  logic [PW-1:0] acc_q, acc_d;

  always_comb begin
    if (run) acc_d = acc_q + inc;
    else     acc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (step) acc_q <= acc_d;
  end

  assign ph_top = acc_q[PW-1 -: OB];

endmodule

// File: rtl/tg_shape.sv
module tg_shape #(
  parameter int DW       = 16,
  parameter int TBL_BITS = 6,
  localparam int OB      = TBL_BITS + 2,
  localparam int TBL_N   = 1 << TBL_BITS
) (
  input  logic                 square,
  input  logic [OB-1:0]        ph_top,
  output logic signed [DW-1:0] wave
);
  import tg_pkg::*;

  localparam int AMP = (1 << (DW - 1)) - 1;

  logic [DW-1:0]       tbl [TBL_N];
  logic [1:0]          quad;
  logic [TBL_BITS-1:0] idx;
  logic signed [DW-1:0] mag;

  for (genvar i = 0; i < TBL_N; i++) begin : g_tbl
    localparam logic [DW-1:0] PT = DW'(sine_pt(i, TBL_BITS, AMP));
    assign tbl[i] = PT;
  end

  assign quad = ph_top[OB-1 -: 2];

  always_comb begin
    idx = quad[0] ? ~ph_top[TBL_BITS-1:0] : ph_top[TBL_BITS-1:0];
    mag = $signed(tbl[idx]);
    if (square) wave = quad[1] ? -DW'(AMP) : DW'(AMP);
    else        wave = quad[1] ? -mag : mag;
  end

endmodule

// File: rtl/tg_gain.sv
module tg_gain #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic signed [DW-1:0] din,
  input  logic [AW-1:0]        code,
  output logic signed [DW-1:0] dout
);
  import tg_pkg::*;

  localparam int FRAC = 15;
  localparam int GW   = FRAC + 2;
  localparam int PRW  = DW + GW + 1;

  logic [GW-1:0]         g;
  logic signed [PRW-1:0] prod;

  always_comb begin
    g    = GW'(gain_q15(int'(code)));
    prod = PRW'(din) * PRW'($signed({1'b0, g}));
    dout = DW'(prod >>> FRAC);
  end

endmodule

// File: rtl/tone_gen.sv
module tone_gen #(
  parameter int PW       = 16,
  parameter int DW       = 16,
  parameter int TBL_BITS = 6,
  parameter int AW       = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_en,
  input  logic                 tone_on,
  input  logic                 ext_ctrl,
  input  logic                 at_valid,
  input  logic                 at_value,
  input  logic                 dual,
  input  logic                 square,
  input  logic [PW-1:0]        freq1,
  input  logic [PW-1:0]        freq2,
  input  logic [AW-1:0]        atten,
  input  logic [1:0]           route,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample,
  output logic [2:0]           dest
);
  import tg_pkg::*;

  localparam int OB     = TBL_BITS + 2;
  localparam int NTONES = 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  // Tone selection for this strobe.
  logic                 run   [NTONES];
  logic [PW-1:0]        inc   [NTONES];
  logic [OB-1:0]        ph    [NTONES];
  logic signed [DW-1:0] wv    [NTONES];
  logic                 pair;

  always_comb begin
    if (ext_ctrl) begin
      run[0] = at_valid;
      inc[0] = at_value ? freq1 : freq2;
      run[1] = 1'b0;
      pair   = 1'b0;
    end else begin
      run[0] = tone_on;
      inc[0] = freq1;
      run[1] = tone_on & dual;
      pair   = dual;
    end
    inc[1] = freq2;
  end

  for (genvar t = 0; t < NTONES; t++) begin : g_tone
    tg_phase #(.PW(PW), .OB(OB)) u_ph (
      .clk   (clk),
      .rst_n (rst_i),
      .step  (sample_en),
      .run   (run[t]),
      .inc   (inc[t]),
      .ph_top(ph[t])
    );
    tg_shape #(.DW(DW), .TBL_BITS(TBL_BITS)) u_sh (
      .square(square),
      .ph_top(ph[t]),
      .wave  (wv[t])
    );
  end

  // Stage 1: mix.
  logic signed [DW-1:0] mix_d, s1_mix_q;
  logic [AW-1:0]        s1_att_q;
  logic [2:0]           s1_dst_q;
  logic                 s1_vld_q;

  always_comb begin
    if (!run[0])   mix_d = '0;
    else if (pair) mix_d = (wv[0] >>> 1) + (wv[1] >>> 1);
    else           mix_d = wv[0];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      s1_mix_q <= '0;
      s1_att_q <= '0;
      s1_dst_q <= '0;
      s1_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= sample_en;
      if (sample_en) begin
        s1_mix_q <= mix_d;
        s1_att_q <= atten;
        s1_dst_q <= route_onehot(route);
      end
    end
  end

  // Stage 2: attenuate and present.
  logic signed [DW-1:0] scaled;

  tg_gain #(.DW(DW), .AW(AW)) u_gain (
    .din (s1_mix_q),
    .code(s1_att_q),
    .dout(scaled)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
      dest       <= '0;
    end else begin
      out_valid <= s1_vld_q;
      if (s1_vld_q) begin
        out_sample <= scaled;
        dest       <= s1_dst_q;
      end
    end
  end

endmodule

// File: rtl/tone_gen_chk.sv
module tone_gen_chk #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sample_en,
  input logic                 tone_on,
  input logic                 ext_ctrl,
  input logic                 at_valid,
  input logic                 dual,
  input logic                 square,
  input logic [AW-1:0]        atten,
  input logic [1:0]           route,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_sample,
  input logic [2:0]           dest
);

  localparam logic signed [DW-1:0] AMP = DW'((1 << (DW - 1)) - 1);

  AST_CADENCE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> ##2 out_valid); // R1

  AST_CADENCE_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(sample_en, 2)); // R1

  AST_SQUARE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !ext_ctrl && tone_on && square && !dual && atten == '0)
    |-> ##2 (out_sample == AMP || out_sample == -AMP)); // R2

  AST_MUTE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && atten > AW'(9)) |-> ##2 (out_sample == '0)); // R5

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !ext_ctrl && !tone_on) |-> ##2 (out_sample == '0)); // R6

  AST_PAUSE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && ext_ctrl && !at_valid) |-> ##2 (out_sample == '0)); // R8

  AST_DEST_EAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && route == 2'd0) |-> ##2 (dest == 3'b001)); // R10

  AST_DEST_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && route == 2'd3) |-> ##2 (dest == 3'b000)); // R10

endmodule

bind tone_gen tone_gen_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/sim_tone_gen.sv
`timescale 1ns/1ps
module sim_tone_gen;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               sample_en, tone_on, ext_ctrl, at_valid, at_value;
  logic               dual, square;
  logic [15:0]        freq1, freq2;
  logic [3:0]         atten;
  logic [1:0]         route;
  logic               out_valid;
  logic signed [15:0] out_sample;
  logic [2:0]         dest;

  always #2.5 clk = ~clk;

  tone_gen u0 (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .tone_on(tone_on),
    .ext_ctrl(ext_ctrl), .at_valid(at_valid), .at_value(at_value),
    .dual(dual), .square(square), .freq1(freq1), .freq2(freq2),
    .atten(atten), .route(route), .out_valid(out_valid),
    .out_sample(out_sample), .dest(dest)
  );

  typedef struct {
    int    exp;
    int    tol;
    int    dst;
    string tag;
  } item_t;

  item_t q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  logic [15:0] pa = '0;
  logic [15:0] pb = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic real wave_of(input logic [15:0] ph, input bit sq);
    if (sq) return ph[15] ? -32767.0 : 32767.0;
    return 32767.0 * $sin(2.0 * 3.14159265358979 * (real'(ph[15:8]) + 0.5) / 256.0);
  endfunction

  // Reference model: expected sample for the current inputs, then phase update.
  task automatic push_expect(input string tag);
    bit ra, rb, pr;
    logic [15:0] ia;
    real pre, g;
    int tol, ea, eb;
    item_t it;
    if (ext_ctrl) begin
      ra = at_valid; ia = at_value ? freq1 : freq2; rb = 1'b0; pr = 1'b0;
    end else begin
      ra = tone_on; ia = freq1; rb = tone_on & dual; pr = dual;
    end
    if (!ra) begin
      pre = 0.0; tol = 0;
    end else if (pr) begin
      if (square) begin
        ea = int'(wave_of(pa, 1'b1)); eb = int'(wave_of(pb, 1'b1));
        pre = real'((ea >>> 1) + (eb >>> 1)); tol = 0;
      end else begin
        pre = (wave_of(pa, 1'b0) + wave_of(pb, 1'b0)) / 2.0; tol = 66;
      end
    end else begin
      pre = wave_of(pa, square); tol = square ? 0 : 64;
    end
    if (atten > 4'd9) begin
      it.exp = 0; it.tol = 0;
    end else begin
      g = 10.0 ** (-0.15 * real'(atten));
      it.exp = int'(pre * g);
      it.tol = tol + ((atten == 4'd0) ? 0 : 2);
    end
    it.dst = (route == 2'd0) ? 1 : (route == 2'd1) ? 2 : (route == 2'd2) ? 4 : 0;
    it.tag = tag;
    q.push_back(it);
    pa = ra ? pa + ia : 16'h0;
    pb = rb ? pb + freq2 : 16'h0;
  endtask

  // Driver: one strobe with output timing checks.
  task automatic strobe(input string tag);
    push_expect(tag);
    @(negedge clk) sample_en = 1'b1;
    @(negedge clk) sample_en = 1'b0;
    chk(out_valid == 1'b0, "R1 early", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R1 on time", int'(out_valid), 1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 single pulse", int'(out_valid), 0);
  endtask

  // Monitor: pops the scoreboard on each produced sample.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R1 unexpected sample", int'(out_sample), 0);
      end else begin
        item_t it;
        int d;
        it = q.pop_front();
        d = int'(out_sample) - it.exp;
        if (d < 0) d = -d;
        chk(d <= it.tol, it.tag, int'(out_sample), it.exp);
        chk(int'(dest) == it.dst, "R10 dest", int'(dest), it.dst);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sample_en = 1'b0; tone_on = 1'b0; ext_ctrl = 1'b0;
    at_valid = 1'b0; at_value = 1'b0; dual = 1'b0; square = 1'b1;
    freq1 = 16'h2000; freq2 = 16'h0; atten = 4'd0; route = 2'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R11 valid", int'(out_valid), 0);
    chk(out_sample == 16'sd0, "R11 sample", int'(out_sample), 0);
    chk(dest == 3'b000, "R11 dest", int'(dest), 0);

    // R2: single square tone, earpiece.
    tone_on = 1'b1;
    for (int i = 0; i < 12; i++) strobe("R2 square");

    // R6: idle resets phase, then restart from zero.
    tone_on = 1'b0;
    for (int i = 0; i < 3; i++) strobe("R6 idle");
    tone_on = 1'b1; freq1 = 16'h3000;
    for (int i = 0; i < 6; i++) strobe("R6 restart");

    // R3: single sine, loudspeaker.
    square = 1'b0; freq1 = 16'h0700; route = 2'd1;
    for (int i = 0; i < 40; i++) strobe("R3 sine");

    // R4: dual sine and dual square, transmit path.
    dual = 1'b1; freq1 = 16'h0500; freq2 = 16'h0B00; route = 2'd2;
    for (int i = 0; i < 24; i++) strobe("R4 dual sine");
    square = 1'b1; freq1 = 16'h1800; freq2 = 16'h2C00;
    for (int i = 0; i < 12; i++) strobe("R4 dual square");

    // R5: every attenuation code on a single square tone.
    dual = 1'b0; freq1 = 16'h4000; route = 2'd0;
    for (int k = 0; k < 16; k++) begin
      atten = 4'(k);
      strobe("R5 atten");
      strobe("R5 atten");
    end
    square = 1'b0; atten = 4'd4;
    for (int i = 0; i < 8; i++) strobe("R5 atten sine");
    atten = 4'd0;

    // R7, R9: external control, dual and tone_on ignored, route none.
    ext_ctrl = 1'b1; tone_on = 1'b0; dual = 1'b1; route = 2'd3;
    freq1 = 16'h0900; freq2 = 16'h1300;
    at_valid = 1'b1; at_value = 1'b1;
    for (int i = 0; i < 5; i++) strobe("R7 f1");
    at_value = 1'b0;
    for (int i = 0; i < 5; i++) strobe("R9 switch to f2");
    at_value = 1'b1;
    for (int i = 0; i < 4; i++) strobe("R9 switch to f1");

    // R8: pause and resume.
    at_valid = 1'b0;
    for (int i = 0; i < 3; i++) strobe("R8 pause");
    at_valid = 1'b1; at_value = 1'b0; square = 1'b1;
    for (int i = 0; i < 6; i++) strobe("R8 resume");

    repeat (6) @(negedge clk);
    chk(q.size() == 0, "R1 all samples produced", q.size(), 0);
    finish_run();
  end

endmodule